// File: doc/BRIEF.md
# Age-Counter Way Replacement Selector

This block chooses which way of a four-way set-associative cache gets overwritten when a line must be brought in. Each way of each set holds a small age value, and the ages in a set always form a permutation. The oldest way, the one holding the largest value, is the candidate. The surrounding cache controller presents a set index on every cycle. It pulses an access strobe, with the way that hit, when a lookup succeeds. It pulses a fill strobe when it overwrites the candidate the selector is currently offering.

A two-bit mode input picks one of four policies:
- **Least-recently-used ordering:** ages are refreshed on hits and on fills.
- **Insertion ordering:** ages change only on fills.
- **Cyclic pointer:** a single pointer shared by all sets names the victim and steps on each fill.
- **Free-running pointer:** a pointer steps on every clock and gives a cheap pseudo-random choice.

The candidate is computed combinationally from stored state. All state changes take effect at the next rising clock edge.

Top module: `way_victim_select`

## Requirements
- R1: While reset is held and after it is released, every set holds age value w in way w (0,1,2,3), and both pointers are 0. After reset the victim is therefore way 3 in mode 0 or 1, and way 0 in mode 2.
- R2: In mode 0 (LRU) and mode 1 (FIFO), victimWay is the way of the set addressed by setIdx whose age is NUM_WAYS-1, that is, the highest age. It follows setIdx and mode within the same cycle.
- R3: In mode 0, an access to way a without a fill takes effect at the next edge. Way a's age becomes 0, every way of that set whose age is below a's old age goes up by one, and the other ways keep their ages.
- R4: In mode 0, a fill is handled as an access to the current victim. The victim's age goes to 0 and every other way of that set goes up by one.
- R5: In mode 1, accesses leave all ages unchanged, and a fill updates the ages exactly as in R4.
- R6: When accValid and fillValid are both high in the same cycle, the fill alone determines the age update, and the access is ignored.
- R7: In mode 2 (round-robin), victimWay equals a single pointer shared by all sets. That pointer advances by one modulo 4 on each fill made in mode 2. Accesses, and fills made in other modes, leave it unchanged.
- R8: In mode 3 (random), victimWay equals a pointer that advances by one modulo 4 on every clock edge, whatever the strobes and setIdx.
- R9: An update changes only the set addressed by setIdx, and the ages of all other sets are untouched.
- R10: Strobes given in mode 2 or mode 3 never change any age.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy: 0 LRU, 1 FIFO, 2 round-robin, 3 random |
| setIdx | input | SET_W | Set addressed this cycle |
| accValid | input | 1 | Hit in the addressed set this cycle |
| accWay | input | WAY_W | Way that hit |
| fillValid | input | 1 | The offered victim of the addressed set is being replaced |
| victimWay | output | WAY_W | Way to replace in the addressed set |

## Verification
A hit and a fill can be reported in the same cycle for the same set, and the fill must win. The bench provokes this with an age state in which the two possible outcomes differ: a fill of way 2 leaves way 1 oldest, while an access to way 1 would leave way 2 oldest. It then judges the result by reading the victim offered on the following cycle. The same clash is repeated in the other modes. In insertion mode and pointer modes, the access half of the clash must also leave the state untouched.

// File: rtl/way_age_pkg.sv
package way_age_pkg;

  typedef enum logic [1:0] {
    MODE_LRU    = 2'd0,
    MODE_FIFO   = 2'd1,
    MODE_RROBIN = 2'd2,
    MODE_RANDOM = 2'd3
  } replMode_e;

  // strobes from the control path to the age store
  typedef struct packed {
    logic promote;    // rewrite the addressed set this edge
    logic useVictim;  // target is the oldest way, not the hit way
  } ageCmd_t;

endpackage

// File: rtl/way_age_store.sv
module way_age_store
  import way_age_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] setIdx,
  input  logic [WAY_W-1:0] accWay,
  input  ageCmd_t          cmd,
  output logic [WAY_W-1:0] oldestWay
);

  localparam logic [WAY_W-1:0] AGE_MAX = WAY_W'(NUM_WAYS - 1);

  logic [WAY_W-1:0] ageMem [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0] ageRow [NUM_WAYS];
  logic [WAY_W-1:0] nextRow[NUM_WAYS];
  logic [WAY_W-1:0] targetWay;
  logic [WAY_W-1:0] targetAge;

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) ageRow[w] = ageMem[setIdx][w];
  end

  always_comb begin
    oldestWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (ageRow[w] == AGE_MAX) oldestWay = WAY_W'(w);
    end
  end

  assign targetWay = cmd.useVictim ? oldestWay : accWay;
  assign targetAge = ageRow[targetWay];

  for (genvar g = 0; g < NUM_WAYS; g++) begin : gWay
    always_comb begin
      if (WAY_W'(g) == targetWay)   nextRow[g] = '0;
      else if (ageRow[g] < targetAge) nextRow[g] = ageRow[g] + WAY_W'(1);
      else                            nextRow[g] = ageRow[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) ageMem[s][w] <= WAY_W'(w);
      end
    end else if (cmd.promote) begin
      for (int w = 0; w < NUM_WAYS; w++) ageMem[setIdx][w] <= nextRow[w];
    end
  end

endmodule

// File: rtl/way_repl_ctrl.sv
module way_repl_ctrl
  import way_age_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             accValid,
  input  logic             fillValid,
  input  logic [WAY_W-1:0] oldestWay,
  output ageCmd_t          cmd,
  output logic [WAY_W-1:0] victimWay
);

  replMode_e        curMode;
  logic [WAY_W-1:0] rrPtr;
  logic [WAY_W-1:0] rndPtr;

  assign curMode = replMode_e'(mode);

  always_comb begin
    cmd.useVictim = fillValid;
    unique case (curMode)
      MODE_LRU:  cmd.promote = fillValid | accValid;
      MODE_FIFO: cmd.promote = fillValid;
      default:   cmd.promote = 1'b0;
    endcase
  end

  always_comb begin
    unique case (curMode)
      MODE_RROBIN: victimWay = rrPtr;
      MODE_RANDOM: victimWay = rndPtr;
      default:     victimWay = oldestWay;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr  <= '0;
      rndPtr <= '0;
    end else begin
      rndPtr <= rndPtr + WAY_W'(1);
      if (curMode == MODE_RROBIN && fillValid) rrPtr <= rrPtr + WAY_W'(1);
    end
  end

endmodule

// File: rtl/way_victim_select.sv
module way_victim_select
  import way_age_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic [SET_W-1:0] setIdx,
  input  logic             accValid,
  input  logic [WAY_W-1:0] accWay,
  input  logic             fillValid,
  output logic [WAY_W-1:0] victimWay
);

  ageCmd_t          cmd;
  logic [WAY_W-1:0] oldestWay;

  way_age_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) store_i (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .accWay(accWay),
    .cmd(cmd), .oldestWay(oldestWay)
  );

  way_repl_ctrl #(.NUM_WAYS(NUM_WAYS)) ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode), .accValid(accValid),
    .fillValid(fillValid), .oldestWay(oldestWay), .cmd(cmd),
    .victimWay(victimWay)
  );

endmodule

// File: rtl/way_victim_select_chk.sv
module way_victim_select_chk
  import way_age_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic [SET_W-1:0] setIdx,
  input logic             accValid,
  input logic [WAY_W-1:0] accWay,
  input logic             fillValid,
  input logic [WAY_W-1:0] victimWay
);

  logic sameCtx;
  assign sameCtx = 1'b1;

  a_r7_rr_steps_on_fill: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RROBIN && fillValid) |=>
      (mode != MODE_RROBIN || victimWay == WAY_W'($past(victimWay) + 1'b1)));

  a_r7_rr_holds_without_fill: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RROBIN && !fillValid) |=>
      (mode != MODE_RROBIN || victimWay == $past(victimWay)));

  a_r8_random_steps_each_clock: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RANDOM) |=>
      (mode != MODE_RANDOM || victimWay == WAY_W'($past(victimWay) + 1'b1)));

  a_r4_fill_moves_victim: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_LRU || mode == MODE_FIFO) && fillValid) |=>
      (setIdx != $past(setIdx) || mode != $past(mode) ||
       victimWay != $past(victimWay)));

  a_r3_hit_on_victim_moves_it: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_LRU && accValid && !fillValid && accWay == victimWay) |=>
      (setIdx != $past(setIdx) || mode != $past(mode) ||
       victimWay != $past(victimWay)));

  a_r5_fifo_ignores_hits: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_FIFO && !fillValid && sameCtx) |=>
      (setIdx != $past(setIdx) || mode != $past(mode) ||
       victimWay == $past(victimWay)));

endmodule

bind way_victim_select way_victim_select_chk #(
  .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)
) chk_i (
  .clk(clk), .rstN(rstN), .mode(mode), .setIdx(setIdx), .accValid(accValid),
  .accWay(accWay), .fillValid(fillValid), .victimWay(victimWay)
);

// File: tb/way_victim_select_tb_top.sv
`timescale 1ns/1ps
module way_victim_select_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] setIdx = '0;
  logic       accValid = 1'b0;
  logic [1:0] accWay = '0;
  logic       fillValid = 1'b0;
  logic [1:0] victimWay;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  way_victim_select #(.NUM_SETS(16), .NUM_WAYS(4)) dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .setIdx(setIdx),
    .accValid(accValid), .accWay(accWay), .fillValid(fillValid),
    .victimWay(victimWay)
  );

  // fields: mode(2) set(4) acc(1) accWay(2) fill(1) expVictim(2) req(4)
  localparam logic [15:0] VEC [20] = '{
    {2'd0, 4'd0, 1'b1, 2'd1, 1'b0, 2'd3, 4'd3},  // R3 ages 1,0,2,3
    {2'd0, 4'd0, 1'b1, 2'd2, 1'b0, 2'd3, 4'd3},  // R3 ages 2,1,0,3
    {2'd0, 4'd0, 1'b1, 2'd3, 1'b0, 2'd0, 4'd3},  // R3 ages 3,2,1,0
    {2'd0, 4'd0, 1'b1, 2'd0, 1'b0, 2'd1, 4'd2},  // R2 ages 0,3,2,1
    {2'd0, 4'd0, 1'b1, 2'd2, 1'b0, 2'd1, 4'd3},  // R3 ages 1,3,0,2
    {2'd0, 4'd0, 1'b0, 2'd0, 1'b1, 2'd3, 4'd4},  // R4 ages 2,0,1,3
    {2'd0, 4'd5, 1'b1, 2'd0, 1'b0, 2'd3, 4'd9},  // R9 set5 untouched by set0
    {2'd0, 4'd5, 1'b1, 2'd3, 1'b0, 2'd2, 4'd9},  // R9 set5 ages 1,2,3,0
    {2'd0, 4'd0, 1'b0, 2'd0, 1'b0, 2'd3, 4'd9},  // R9 set0 kept
    {2'd1, 4'd0, 1'b1, 2'd3, 1'b0, 2'd3, 4'd5},  // R5 hit ignored
    {2'd1, 4'd0, 1'b0, 2'd0, 1'b1, 2'd0, 4'd5},  // R5 ages 3,1,2,0
    {2'd1, 4'd0, 1'b0, 2'd0, 1'b1, 2'd2, 4'd5},  // R5 ages 0,2,3,1
    {2'd0, 4'd0, 1'b1, 2'd1, 1'b1, 2'd1, 4'd6},  // R6 fill wins: 1,3,0,2
    {2'd2, 4'd0, 1'b0, 2'd0, 1'b0, 2'd0, 4'd7},  // R7 earlier fills did not step
    {2'd2, 4'd0, 1'b0, 2'd0, 1'b1, 2'd1, 4'd7},  // R7
    {2'd2, 4'd0, 1'b0, 2'd0, 1'b1, 2'd2, 4'd7},  // R7
    {2'd2, 4'd3, 1'b1, 2'd0, 1'b0, 2'd2, 4'd7},  // R7 hit ignored
    {2'd2, 4'd0, 1'b0, 2'd0, 1'b1, 2'd3, 4'd7},  // R7
    {2'd2, 4'd0, 1'b1, 2'd3, 1'b1, 2'd0, 4'd7},  // R7 wrap
    {2'd0, 4'd0, 1'b0, 2'd0, 1'b0, 2'd1, 4'd10}  // R10 ages unchanged
  };

  task automatic check(input int req, input logic [1:0] exp, input string what);
    nChecks++;
    if (victimWay !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: victimWay=%0d expected=%0d", req, what, victimWay, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [1:0] a;
    repeat (3) @(negedge clk);
    // R1 while reset is held
    mode = 2'd0; setIdx = 4'd7; #1 check(1, 2'd3, "LRU victim in reset");
    rstN = 1'b1;
    @(negedge clk); #1 check(1, 2'd3, "LRU victim after reset");
    mode = 2'd2; #1 check(1, 2'd0, "RR pointer after reset");

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      mode = VEC[i][15:14]; setIdx = VEC[i][13:10];
      accValid = VEC[i][9]; accWay = VEC[i][8:7]; fillValid = VEC[i][6];
      @(negedge clk);
      accValid = 1'b0; fillValid = 1'b0;
      #1 check(int'(VEC[i][3:0]), VEC[i][5:4], $sformatf("row %0d", i));
    end

    // R8 random pointer steps every clock, regardless of strobes
    @(negedge clk); mode = 2'd3; setIdx = 4'd0;
    #1 a = victimWay;
    @(negedge clk); #1 check(8, a + 2'd1, "random idle step");
    accValid = 1'b1; accWay = 2'd2; fillValid = 1'b1;
    @(negedge clk); accValid = 1'b0; fillValid = 1'b0;
    #1 check(8, a + 2'd2, "random step with strobes");
    @(negedge clk); #1 check(8, a + 2'd3, "random step again");
    // R10 the random-mode fill left set 0 ages alone
    mode = 2'd0; #1 check(10, 2'd1, "ages after random fill");

    // R1 reset mid-run restores ages and pointer
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1 check(1, 2'd3, "LRU victim after re-reset");
    mode = 2'd2; #1 check(1, 2'd0, "RR pointer after re-reset");

    finishRun();
  end

endmodule